// File: doc/BRIEF.md
# Serial Register-Access Message Handler

This block connects a framed byte link to an on-chip register bus. A host sends a command frame as a stream of bytes. The frame carries a destination station byte, a source station byte, a 16-bit command word, an optional data byte and a 16-bit frame check sequence. The block keeps only frames that are addressed to its own station and that arrive intact. It then decodes the command as a register write or a register read and performs one access on the register bus. Where the acknowledge policy requires it, the block sends back an acknowledge frame on its transmit byte stream.

Flag insertion, bit stuffing and line coding are handled by the surrounding link layer. Bytes arrive already assembled, with the first line bit in bit 0. Start-of-frame and end-of-frame strobes mark the first and last byte of a frame. The block has two internal settings, its own station address and an acknowledge-enable bit. Both sit at two reserved addresses of the register space, so the host reaches them with ordinary read and write commands.

Top module: `regmsg_handler`

## Requirements
- R1: A received frame is accepted only if all of these hold: its check sequence is good, it has at least 6 bytes, bits 5:0 of its first byte equal the current station address, and bits 7:6 of that byte (response flag in bit 6, master flag in bit 7) are both 0. Any other frame causes no register strobe and no acknowledge.
- R2: The check sequence is the HDLC CRC-16. It uses polynomial x^16+x^12+x^5+1, is fed least significant bit first, and is preset to all ones. The transmitted value is the ones complement, sent as two bytes with the low byte first. On receive, the block runs the CRC over every byte including the check bytes and expects the residue 0xF0B8. On transmit, the block computes the CRC over every byte before the check bytes.
- R3: Frame layout is: destination byte, source byte, command word low byte, command word high byte, then a data byte for writes only, then the check bytes. In the command word, bits 15:14 hold the operation code (00 = write, 01 = read) and bits 13:0 hold the register address. A correct write frame has 7 bytes and a correct read frame has 6.
- R4: Only bits 9:0 of the register address appear on `reg_addr`. Bits 13:10 have no effect on which register is accessed.
- R5: A correct write to a non-reserved address raises `reg_wr` for exactly one cycle, with `reg_addr` and `reg_wdata` valid in that cycle. A correct read raises `reg_rd` for one cycle and takes `reg_rdata` in the following cycle. The two strobes are never high together, and neither is high while an acknowledge is being sent.
- R6: The acknowledge frame is sent as one gapless run of bytes, first byte flagged by `tx_sof` and last by `tx_eof`. Its bytes are, in order: the command's source byte; the byte {0, 1, station bits of the command's destination}; the command word echoed low byte first; the status byte; for a successful read only, the read data byte; then the check bytes. In the status byte, bit 2 flags a bad operation code and bit 3 flags a bad length. Bits 0 and 1 (check and address errors) and bits 7:4 are always 0.
- R7: Read commands are always acknowledged. A write command is acknowledged only if the acknowledge-enable bit was set before that command was processed.
- R8: An operation code of 10 or 11 causes no register access and no settings change. Such a frame is acknowledged with status 0x04 and no data byte, whatever its length.
- R9: A read or write frame of the wrong length causes no register access. It is acknowledged with status 0x08 and no data byte; a write is acknowledged only when acknowledge-enable is set.
- R10: The station address is loaded from `strap_addr` while reset is asserted. A write to reserved address 0x3FE sets it from data bits 5:0, and a read of 0x3FE returns {00, station}. Address 0x3FF holds acknowledge-enable in bit 0; it resets to 0, and a read returns {0000000, enable}. Accesses to 0x3FE and 0x3FF never strobe the register bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_addr | input | 6 | Station address loaded during reset |
| rx_valid | input | 1 | Received byte valid |
| rx_sof | input | 1 | Received byte is the first of a frame |
| rx_eof | input | 1 | Received byte is the last of a frame |
| rx_data | input | 8 | Received byte, bit 0 first on the line |
| tx_valid | output | 1 | Transmit byte valid |
| tx_sof | output | 1 | Transmit byte is the first of the acknowledge |
| tx_eof | output | 1 | Transmit byte is the last of the acknowledge |
| tx_data | output | 8 | Transmit byte, bit 0 first on the line |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | 10 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, valid the cycle after `reg_rd` |

## Verification
The assertions assume a half-duplex host. No new frame starts until the acknowledge for the previous accepted command has ended, or until the block has had a few idle cycles after a frame that gets no acknowledge. They also assume that the register bus returns read data in the cycle after the strobe. The bench drives each frame as a run of back-to-back bytes and then waits for the complete acknowledge, or for a fixed quiet window, before the next frame. Its register model answers reads one cycle after `reg_rd`, so the stimulus stays within both assumptions.

// File: rtl/regmsg_pkg.sv
package regmsg_pkg;

    localparam int CNT_W   = 4;   // frame byte counter, saturating
    localparam int STN_W   = 6;   // station address bits
    localparam int MIN_LEN = 6;   // shortest frame carrying a command word
    localparam int WR_LEN  = 7;
    localparam int RD_LEN  = 6;

    localparam logic [15:0] CRC_POLY_REF = 16'h8408;
    localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
    localparam logic [15:0] CRC_RESIDUE  = 16'hF0B8;

    // status byte flag positions
    localparam int ST_CRC = 0;
    localparam int ST_ADR = 1;
    localparam int ST_OP  = 2;
    localparam int ST_LEN = 3;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_READ  = 2'b01,
        OP_RSV2  = 2'b10,
        OP_RSV3  = 2'b11
    } op_e;

    typedef struct packed {
        logic [7:0]       dst;
        logic [7:0]       src;
        logic [15:0]      word;
        logic [7:0]       wdata;
        logic [CNT_W-1:0] nbytes;
        logic             crc_ok;
    } rx_frame_t;

    typedef struct packed {
        logic [7:0]  dst;
        logic [7:0]  src;
        logic [15:0] word;
        logic [7:0]  status;
        logic [7:0]  rdata;
        logic        with_data;
    } ack_frame_t;

    // one byte through the reflected CRC register, bit 0 first
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            r = (r >> 1) ^ (((r[0] ^ b[i]) == 1'b1) ? CRC_POLY_REF : 16'h0000);
        end
        return r;
    endfunction

endpackage

// File: rtl/regmsg_rx.sv
module regmsg_rx
    import regmsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic       rx_sof,
    input  logic       rx_eof,
    input  logic [7:0] rx_data,
    output logic       frm_done,
    output rx_frame_t  frm
);

    logic [15:0]      crc_q, crc_base, crc_nx;
    logic [CNT_W-1:0] cnt_q, cnt_base, cnt_nx;
    logic             active_q;
    logic             take;

    assign take = rx_valid && (rx_sof || active_q);

    always_comb begin
        crc_base = rx_sof ? CRC_PRESET : crc_q;
        cnt_base = rx_sof ? '0 : cnt_q;
        crc_nx   = crc_step(crc_base, rx_data);
        cnt_nx   = (&cnt_base) ? cnt_base : cnt_base + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            crc_q    <= CRC_PRESET;
            cnt_q    <= '0;
            frm_done <= 1'b0;
            frm      <= '0;
        end else begin
            frm_done <= 1'b0;
            if (take) begin
                crc_q    <= crc_nx;
                cnt_q    <= cnt_nx;
                active_q <= !rx_eof;
                case (cnt_base)
                    CNT_W'(0): frm.dst        <= rx_data;
                    CNT_W'(1): frm.src        <= rx_data;
                    CNT_W'(2): frm.word[7:0]  <= rx_data;
                    CNT_W'(3): frm.word[15:8] <= rx_data;
                    CNT_W'(4): frm.wdata      <= rx_data;
                    default:   ;
                endcase
                if (rx_eof) begin
                    frm_done   <= 1'b1;
                    frm.nbytes <= cnt_nx;
                    frm.crc_ok <= (crc_nx == CRC_RESIDUE);
                end
            end
        end
    end

endmodule

// File: rtl/regmsg_tx.sv
module regmsg_tx
    import regmsg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  ack_frame_t ack,
    output logic       tx_valid,
    output logic       tx_sof,
    output logic       tx_eof,
    output logic [7:0] tx_data,
    output logic       done
);

    ack_frame_t       a_q;
    logic             busy_q;
    logic [CNT_W-1:0] idx_q;
    logic [15:0]      crc_q;
    logic [CNT_W-1:0] body_len;
    logic [7:0]       body_byte, out_byte;
    logic             in_body, last;

    assign body_len = a_q.with_data ? CNT_W'(6) : CNT_W'(5);

    always_comb begin
        case (idx_q)
            CNT_W'(0): body_byte = a_q.dst;
            CNT_W'(1): body_byte = a_q.src;
            CNT_W'(2): body_byte = a_q.word[7:0];
            CNT_W'(3): body_byte = a_q.word[15:8];
            CNT_W'(4): body_byte = a_q.status;
            default:   body_byte = a_q.rdata;
        endcase
        in_body = idx_q < body_len;
        last    = idx_q == body_len + CNT_W'(1);
        if (in_body)
            out_byte = body_byte;
        else if (idx_q == body_len)
            out_byte = ~crc_q[7:0];
        else
            out_byte = ~crc_q[15:8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q      <= '0;
            busy_q   <= 1'b0;
            idx_q    <= '0;
            crc_q    <= CRC_PRESET;
            tx_valid <= 1'b0;
            tx_sof   <= 1'b0;
            tx_eof   <= 1'b0;
            tx_data  <= '0;
            done     <= 1'b0;
        end else begin
            done     <= 1'b0;
            tx_valid <= 1'b0;
            tx_sof   <= 1'b0;
            tx_eof   <= 1'b0;
            if (start && !busy_q) begin
                a_q    <= ack;
                busy_q <= 1'b1;
                idx_q  <= '0;
                crc_q  <= CRC_PRESET;
            end else if (busy_q) begin
                tx_valid <= 1'b1;
                tx_sof   <= (idx_q == '0);
                tx_eof   <= last;
                tx_data  <= out_byte;
                if (in_body) crc_q <= crc_step(crc_q, body_byte);
                idx_q <= idx_q + CNT_W'(1);
                if (last) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/regmsg_handler.sv
module regmsg_handler
    import regmsg_pkg::*;
#(
    parameter int              RA_W         = 10,
    parameter logic [RA_W-1:0] CFG_STN_ADDR = 10'h3FE,
    parameter logic [RA_W-1:0] CFG_CTL_ADDR = 10'h3FF,
    parameter logic            ACK_EN_INIT  = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [5:0]      strap_addr,
    input  logic            rx_valid,
    input  logic            rx_sof,
    input  logic            rx_eof,
    input  logic [7:0]      rx_data,
    output logic            tx_valid,
    output logic            tx_sof,
    output logic            tx_eof,
    output logic [7:0]      tx_data,
    output logic            reg_wr,
    output logic            reg_rd,
    output logic [RA_W-1:0] reg_addr,
    output logic [7:0]      reg_wdata,
    input  logic [7:0]      reg_rdata
);

    typedef enum logic [1:0] {S_IDLE, S_ACCESS, S_FETCH, S_SEND} st_e;

    rx_frame_t  frm;
    logic       frm_done;
    ack_frame_t ack_q;
    logic       tx_start, tx_done;

    logic [STN_W-1:0] stn_q;
    logic             ack_en_q;
    st_e              st_q;
    logic             cfg_hit_q;
    logic [7:0]       cfg_val_q;

    op_e             op;
    logic            is_wr, is_rd, bad_op, len_err, do_acc, accept, is_cfg, send_ack;
    logic [RA_W-1:0] ra;
    logic [7:0]      status;

    regmsg_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .rx_valid (rx_valid),
        .rx_sof   (rx_sof),
        .rx_eof   (rx_eof),
        .rx_data  (rx_data),
        .frm_done (frm_done),
        .frm      (frm)
    );

    always_comb begin
        op       = op_e'(frm.word[15:14]);
        is_wr    = (op == OP_WRITE);
        is_rd    = (op == OP_READ);
        bad_op   = !is_wr && !is_rd;
        ra       = frm.word[RA_W-1:0];
        accept   = frm.crc_ok && (frm.nbytes >= CNT_W'(MIN_LEN)) &&
                   (frm.dst[STN_W-1:0] == stn_q) && (frm.dst[7:6] == 2'b00);
        len_err  = !bad_op && (frm.nbytes != (is_wr ? CNT_W'(WR_LEN) : CNT_W'(RD_LEN)));
        do_acc   = !bad_op && !len_err;
        is_cfg   = (ra == CFG_STN_ADDR) || (ra == CFG_CTL_ADDR);
        send_ack = !(is_wr && !ack_en_q);
        status          = '0;
        status[ST_OP]   = bad_op;
        status[ST_LEN]  = len_err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= S_IDLE;
            stn_q     <= strap_addr;
            ack_en_q  <= ACK_EN_INIT;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            reg_addr  <= '0;
            reg_wdata <= '0;
            ack_q     <= '0;
            tx_start  <= 1'b0;
            cfg_hit_q <= 1'b0;
            cfg_val_q <= '0;
        end else begin
            reg_wr   <= 1'b0;
            reg_rd   <= 1'b0;
            tx_start <= 1'b0;
            case (st_q)
                S_IDLE: begin
                    if (frm_done && accept) begin
                        reg_addr  <= ra;
                        reg_wdata <= frm.wdata;
                        reg_wr    <= do_acc && is_wr && !is_cfg;
                        reg_rd    <= do_acc && is_rd && !is_cfg;
                        if (do_acc && is_wr && ra == CFG_STN_ADDR) stn_q    <= frm.wdata[STN_W-1:0];
                        if (do_acc && is_wr && ra == CFG_CTL_ADDR) ack_en_q <= frm.wdata[0];
                        ack_q.dst       <= frm.src;
                        ack_q.src       <= {1'b0, 1'b1, frm.dst[STN_W-1:0]};
                        ack_q.word      <= frm.word;
                        ack_q.status    <= status;
                        ack_q.rdata     <= '0;
                        ack_q.with_data <= do_acc && is_rd;
                        cfg_hit_q       <= is_cfg;
                        cfg_val_q       <= (ra == CFG_STN_ADDR) ? {2'b00, stn_q} : {7'b0, ack_en_q};
                        if (send_ack) st_q <= S_ACCESS;
                    end
                end
                S_ACCESS: st_q <= S_FETCH;
                S_FETCH: begin
                    ack_q.rdata <= cfg_hit_q ? cfg_val_q : reg_rdata;
                    tx_start    <= 1'b1;
                    st_q        <= S_SEND;
                end
                default: begin
                    if (tx_done) st_q <= S_IDLE;
                end
            endcase
        end
    end

    regmsg_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .start    (tx_start),
        .ack      (ack_q),
        .tx_valid (tx_valid),
        .tx_sof   (tx_sof),
        .tx_eof   (tx_eof),
        .tx_data  (tx_data),
        .done     (tx_done)
    );

endmodule

// File: rtl/regmsg_handler_chk.sv
module regmsg_handler_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_valid,
    input logic       tx_sof,
    input logic       tx_eof,
    input logic [1:0] tx_flags,
    input logic       reg_wr,
    input logic       reg_rd
);

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));

    // R5
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);

    // R5
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> !reg_rd);

    // R5
    quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (!reg_wr && !reg_rd));

    // R6
    frame_marks_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_sof || tx_eof) |-> tx_valid);

    // R6
    gapless_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_eof) |=> tx_valid);

    // R6
    ack_src_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_sof) |=> (tx_valid && !tx_sof && tx_flags == 2'b01));

endmodule

bind regmsg_handler regmsg_handler_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_valid (tx_valid),
    .tx_sof   (tx_sof),
    .tx_eof   (tx_eof),
    .tx_flags (tx_data[7:6]),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd)
);

// File: tb/regmsg_handler_tb.sv
module regmsg_handler_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] strap_addr = 6'h15;
    logic       rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_valid, tx_sof, tx_eof;
    logic [7:0] tx_data;
    logic       reg_wr, reg_rd;
    logic [9:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata = 8'h00;

    always #4 clk = ~clk;

    regmsg_handler u_dut (
        .clk(clk), .rst(rst), .strap_addr(strap_addr),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_data(tx_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    localparam logic [7:0] HOST = 8'h82;
    localparam logic [7:0] ME0  = 8'h15;

    int n_chk = 0;
    int n_fail = 0;

    // register file model, read data one cycle after the strobe
    logic [7:0] mem [0:1023];
    int         wr_cnt = 0, rd_cnt = 0;
    logic [9:0] last_waddr = '0;
    logic [7:0] last_wdata = '0;
    always @(negedge clk) begin
        if (reg_wr) begin
            mem[reg_addr] <= reg_wdata;
            wr_cnt        <= wr_cnt + 1;
            last_waddr    <= reg_addr;
            last_wdata    <= reg_wdata;
        end
        if (reg_rd) begin
            reg_rdata <= mem[reg_addr];
            rd_cnt    <= rd_cnt + 1;
        end
    end

    // acknowledge collector
    logic [7:0] abuf [0:15];
    int         alen = 0;
    int         ack_cnt = 0;
    always @(negedge clk) begin
        if (tx_valid) begin
            if (tx_sof) begin
                abuf[0] <= tx_data;
                alen    <= 1;
            end else if (alen < 16) begin
                abuf[alen] <= tx_data;
                alen       <= alen + 1;
            end
            if (tx_eof) ack_cnt <= ack_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // shift-left CRC model on line-order bits, result mapped to byte order
    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            logic f;
            f = r[15] ^ b[i];
            r = {r[14:0], 1'b0};
            if (f) r = r ^ 16'h1021;
        end
        return r;
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    logic [7:0] fb [0:15];
    int         fn;
    logic [7:0] eb [0:15];
    int         en;

    task automatic fcs_cmd();
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < fn; i++) c = ref_crc(c, fb[i]);
        fb[fn]   = rev8(~c[15:8]);
        fb[fn+1] = rev8(~c[7:0]);
        fn = fn + 2;
    endtask

    task automatic fcs_exp();
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < en; i++) c = ref_crc(c, eb[i]);
        eb[en]   = rev8(~c[15:8]);
        eb[en+1] = rev8(~c[7:0]);
        en = en + 2;
    endtask

    task automatic build_cmd(input logic [7:0] dst, input logic [1:0] op,
                             input logic [13:0] addr, input logic [7:0] data, input bit with_data);
        logic [15:0] w;
        w     = {op, addr};
        fb[0] = dst;
        fb[1] = HOST;
        fb[2] = w[7:0];
        fb[3] = w[15:8];
        fn    = 4;
        if (with_data) begin
            fb[4] = data;
            fn    = 5;
        end
        fcs_cmd();
    endtask

    task automatic build_ack(input logic [7:0] src, input logic [1:0] op, input logic [13:0] addr,
                             input logic [7:0] status, input logic [7:0] data, input bit with_data);
        logic [15:0] w;
        w     = {op, addr};
        eb[0] = HOST;
        eb[1] = src;
        eb[2] = w[7:0];
        eb[3] = w[15:8];
        eb[4] = status;
        en    = 5;
        if (with_data) begin
            eb[5] = data;
            en    = 6;
        end
        fcs_exp();
    endtask

    task automatic send_frame();
        for (int i = 0; i < fn; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = (i == fn - 1);
            rx_data  = fb[i];
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
        rx_eof   = 1'b0;
    endtask

    task automatic expect_ack(input string req);
        int s;
        bit got;
        int bad;
        s   = ack_cnt;
        got = 1'b0;
        for (int k = 0; k < 60; k++) begin
            @(posedge clk);
            if (ack_cnt != s) begin
                got = 1'b1;
                break;
            end
        end
        check(got, req, "ack present", {31'b0, got}, 32'd1);
        if (got) begin
            check(alen == en, req, "ack length", alen, en);
            bad = -1;
            for (int i = 0; i < en; i++)
                if (bad < 0 && abuf[i] !== eb[i]) bad = i;
            if (bad < 0) check(1'b1, req, "ack bytes", 0, 0);
            else check(1'b0, req, $sformatf("ack byte %0d", bad), abuf[bad], eb[bad]);
        end
        repeat (3) @(posedge clk);
    endtask

    task automatic expect_none(input string req);
        int s;
        s = ack_cnt;
        repeat (60) @(posedge clk);
        check(ack_cnt == s, req, "no ack", ack_cnt - s, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(tx_valid == 1'b0, "R6", "tx_valid after reset", tx_valid, 0);
        check(reg_wr == 1'b0 && reg_rd == 1'b0, "R5", "strobes after reset", {reg_wr, reg_rd}, 0);
    endtask

    task automatic t_write_silent();
        int w0;
        w0 = wr_cnt;
        build_cmd(ME0, 2'b00, 14'h0123, 8'hA5, 1);
        send_frame();
        expect_none("R7");
        check(wr_cnt == w0 + 1, "R5", "write strobes", wr_cnt - w0, 1);
        check(last_waddr == 10'h123, "R5", "write address", last_waddr, 10'h123);
        check(last_wdata == 8'hA5, "R3", "write data", last_wdata, 8'hA5);
    endtask

    task automatic t_read_back();
        int r0;
        r0 = rd_cnt;
        build_cmd(ME0, 2'b01, 14'h0123, 8'h00, 0);
        send_frame();
        build_ack(8'h55, 2'b01, 14'h0123, 8'h00, 8'hA5, 1);
        expect_ack("R6 R7 R10");
        check(rd_cnt == r0 + 1, "R5", "read strobes", rd_cnt - r0, 1);
    endtask

    task automatic t_upper_bits();
        build_cmd(ME0, 2'b00, 14'h3C40, 8'h3C, 1);
        send_frame();
        expect_none("R7");
        check(last_waddr == 10'h040, "R4", "upper bits dropped", last_waddr, 10'h040);
        build_cmd(ME0, 2'b01, 14'h1840, 8'h00, 0);
        send_frame();
        build_ack(8'h55, 2'b01, 14'h1840, 8'h00, 8'h3C, 1);
        expect_ack("R4");
    endtask

    task automatic t_bad_fcs();
        int w0;
        w0 = wr_cnt;
        build_cmd(ME0, 2'b00, 14'h0050, 8'h11, 1);
        fb[fn-1] = fb[fn-1] ^ 8'h01;
        send_frame();
        expect_none("R2");
        build_cmd(ME0, 2'b00, 14'h0050, 8'h11, 1);
        fb[4] = fb[4] ^ 8'h80;
        send_frame();
        expect_none("R2");
        check(wr_cnt == w0, "R2", "writes on bad check", wr_cnt - w0, 0);
    endtask

    task automatic t_foreign();
        int r0;
        r0 = rd_cnt;
        build_cmd(8'h16, 2'b01, 14'h0123, 8'h00, 0);
        send_frame();
        expect_none("R1");
        build_cmd(8'h55, 2'b01, 14'h0123, 8'h00, 0);
        send_frame();
        expect_none("R1");
        fb[0] = ME0;
        fb[1] = HOST;
        fn    = 2;
        fcs_cmd();
        send_frame();
        expect_none("R1");
        check(rd_cnt == r0, "R1", "reads on dropped frames", rd_cnt - r0, 0);
    endtask

    task automatic t_ack_enable();
        int w0;
        w0 = wr_cnt;
        build_cmd(ME0, 2'b00, 14'h03FF, 8'h01, 1);
        send_frame();
        expect_none("R7");
        check(wr_cnt == w0, "R10", "reserved write on bus", wr_cnt - w0, 0);
        build_cmd(ME0, 2'b00, 14'h0200, 8'h77, 1);
        send_frame();
        build_ack(8'h55, 2'b00, 14'h0200, 8'h00, 8'h00, 0);
        expect_ack("R7");
        check(wr_cnt == w0 + 1 && last_wdata == 8'h77, "R5", "acked write data", last_wdata, 8'h77);
    endtask

    task automatic t_bad_op();
        int w0, r0;
        w0 = wr_cnt;
        r0 = rd_cnt;
        build_cmd(ME0, 2'b10, 14'h0123, 8'h00, 0);
        send_frame();
        build_ack(8'h55, 2'b10, 14'h0123, 8'h04, 8'h00, 0);
        expect_ack("R8");
        build_cmd(ME0, 2'b11, 14'h0200, 8'h99, 1);
        send_frame();
        build_ack(8'h55, 2'b11, 14'h0200, 8'h04, 8'h00, 0);
        expect_ack("R8");
        check(wr_cnt == w0 && rd_cnt == r0, "R8", "access on bad op",
              (wr_cnt - w0) + (rd_cnt - r0), 0);
    endtask

    task automatic t_len();
        int w0, r0;
        w0 = wr_cnt;
        r0 = rd_cnt;
        build_cmd(ME0, 2'b01, 14'h0123, 8'h5A, 1);
        send_frame();
        build_ack(8'h55, 2'b01, 14'h0123, 8'h08, 8'h00, 0);
        expect_ack("R9");
        build_cmd(ME0, 2'b00, 14'h0200, 8'h00, 0);
        send_frame();
        build_ack(8'h55, 2'b00, 14'h0200, 8'h08, 8'h00, 0);
        expect_ack("R9");
        check(wr_cnt == w0 && rd_cnt == r0, "R9", "access on bad length",
              (wr_cnt - w0) + (rd_cnt - r0), 0);
    endtask

    task automatic t_station();
        int w0, r0;
        w0 = wr_cnt;
        r0 = rd_cnt;
        build_cmd(ME0, 2'b00, 14'h03FE, 8'h2A, 1);
        send_frame();
        build_ack(8'h55, 2'b00, 14'h03FE, 8'h00, 8'h00, 0);
        expect_ack("R10");
        build_cmd(8'h2A, 2'b01, 14'h03FE, 8'h00, 0);
        send_frame();
        build_ack(8'h6A, 2'b01, 14'h03FE, 8'h00, 8'h2A, 1);
        expect_ack("R10");
        build_cmd(8'h2A, 2'b01, 14'h03FF, 8'h00, 0);
        send_frame();
        build_ack(8'h6A, 2'b01, 14'h03FF, 8'h00, 8'h01, 1);
        expect_ack("R10");
        build_cmd(ME0, 2'b01, 14'h0123, 8'h00, 0);
        send_frame();
        expect_none("R1");
        check(wr_cnt == w0 && rd_cnt == r0, "R10", "reserved access on bus",
              (wr_cnt - w0) + (rd_cnt - r0), 0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_write_silent();
        t_read_back();
        t_upper_bits();
        t_bad_fcs();
        t_foreign();
        t_ack_enable();
        t_bad_op();
        t_len();
        t_station();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule